// File: doc/BRIEF.md
# TDM Frame Sync Generator

This block sets the bit, slot and frame timing for a time-division multiplexed audio link. It runs on the system clock. A one-cycle bit enable, `bit_en`, marks each serial bit period. The enable stands for the falling edge of the serial clock, where transmit data is launched. Each bit period advances a bit counter inside the current slot and a slot counter inside the frame. From these counters the block drives the frame sync pin and two strobes for the data serializers. One strobe marks the first bit of every slot. The other marks the first bit of the frame.

Four inputs set the frame shape:
- `cfg_slots`: slots per frame, minus one.
- `cfg_size`: slot length.
- `cfg_width`: sync pulse shape, which is one bit, one whole slot, or a half-frame word select.
- `cfg_inv`: inverts the sync output.

The block copies all four into a shadow register on the first enable after reset, and again at every frame wrap. A change in mid-frame therefore never breaks the frame in progress. With these choices one counter set serves both two-channel I2S word-select framing and multi-slot TDM framing.

The controller has two states. ST_IDLE holds after reset with every output inactive. The transition IDLE_TO_RUN happens on the first `bit_en`, which loads the configuration and places the counters at slot 0, bit 0. ST_RUN then stays in ST_RUN for good; only reset returns it to ST_IDLE.

Top module: `tdm_fsync_gen`

## Requirements
- R1: After reset and until the first `bit_en`, `fsync`, `slot_idx`, `bit_idx`, `slot_start` and `frame_start` are all 0.
- R2: `bit_idx` counts 0 to 8*(`cfg_size`+1)-1 within a slot, so size codes 0, 1, 2 and 3 give 8, 16, 24 and 32 bits. It advances only on clock edges where `bit_en` is 1, and every output holds on cycles without `bit_en`.
- R3: `slot_idx` counts 0 to `cfg_slots`, giving 1 to 8 slots. It returns to 0 after the last bit of the last slot.
- R4: With `cfg_width` 0 (bit mode) and `cfg_inv` 0, `fsync` is 1 only during bit 0 of slot 0. Code 3 behaves the same as code 0.
- R5: With `cfg_width` 1 (slot mode) and `cfg_inv` 0, `fsync` is 1 for all of slot 0.
- R6: With `cfg_width` 2 (half mode) and `cfg_inv` 0, `fsync` is 0 for the first half of the frame's bit periods and 1 for the second half. With an odd slot count the change falls inside a slot.
- R7: With `cfg_inv` 1, `fsync` is the complement of its R4 to R6 value while running.
- R8: `slot_start` is 1 during bit 0 of every slot. `frame_start` is 1 only during bit 0 of slot 0.
- R9: Configuration inputs are sampled only at the first `bit_en` after reset and at the `bit_en` that wraps a frame. A change in mid-frame has no effect until the next frame starts.
- R10: The first `bit_en` after reset starts a frame: after that edge the outputs show slot 0, bit 0 with both strobes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One serial bit period (transmit launch edge) |
| cfg_slots | input | 3 | Slots per frame minus one |
| cfg_size | input | 2 | Slot size code: 8/16/24/32 bits |
| cfg_width | input | 2 | Sync shape: 0 bit, 1 slot, 2 half frame, 3 as bit |
| cfg_inv | input | 1 | Invert sync output |
| fsync | output | 1 | Frame sync / word select |
| slot_idx | output | 3 | Current slot |
| bit_idx | output | 5 | Bit position inside the slot |
| slot_start | output | 1 | First bit of a slot |
| frame_start | output | 1 | First bit of a frame |

## Verification
The bench changes the configuration in the middle of a frame. A design that applied the change at once would show a wrong slot length or sync shape before the frame boundary. Half mode is run with three slots, where the level change falls in the middle of slot 1, and with eight 32-bit slots, where the frame is 256 bits long. A halving that ignored the odd slot count, or a position counter that was too narrow, would switch at the wrong bit. The bench also spaces the enables apart with idle cycles, which catches counters that advance without `bit_en`. Reset is asserted in mid-frame to show that the outputs return to the idle state.

// File: rtl/tdm_fsync_pkg.sv
package tdm_fsync_pkg;
    localparam int SLOT_W = 3;
    localparam int SZ_W   = 2;
    localparam int BIT_W  = 5;
    localparam int POS_W  = SLOT_W + BIT_W;
    localparam int TOT_W  = POS_W + 1;

    typedef enum logic [1:0] {
        FSW_BIT  = 2'd0,
        FSW_SLOT = 2'd1,
        FSW_HALF = 2'd2,
        FSW_RSVD = 2'd3
    } fsw_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic [SLOT_W-1:0] slots;
        logic [SZ_W-1:0]   size;
        fsw_mode_e         width;
        logic              inv;
    } frame_cfg_t;

    // Bits per slot: 8 * (code + 1)
    function automatic logic [BIT_W:0] slot_bits(input logic [SZ_W-1:0] code);
        logic [BIT_W:0] n;
        n = {{(BIT_W+1-SZ_W){1'b0}}, code} + 1'b1;
        return n << 3;
    endfunction
endpackage

// File: rtl/tdm_cfg_shadow.sv
module tdm_cfg_shadow
    import tdm_fsync_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  frame_cfg_t d,
    output frame_cfg_t q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end
endmodule

// File: rtl/tdm_pos_counter.sv
module tdm_pos_counter #(
    parameter int SLOT_W = 3,
    parameter int BIT_W  = 5,
    parameter int POS_W  = SLOT_W + BIT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic [BIT_W-1:0]  last_bit,
    input  logic [SLOT_W-1:0] last_slot,
    output logic [BIT_W-1:0]  bit_idx,
    output logic [SLOT_W-1:0] slot_idx,
    output logic [POS_W-1:0]  pos,
    output logic              frame_wrap
);
    logic end_slot;

    always_comb begin
        end_slot   = (bit_idx == last_bit);
        frame_wrap = step && end_slot && (slot_idx == last_slot);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_idx  <= '0;
            slot_idx <= '0;
            pos      <= '0;
        end else if (step) begin
            if (end_slot) begin
                bit_idx <= '0;
                if (slot_idx == last_slot) begin
                    slot_idx <= '0;
                    pos      <= '0;
                end else begin
                    slot_idx <= slot_idx + 1'b1;
                    pos      <= pos + 1'b1;
                end
            end else begin
                bit_idx <= bit_idx + 1'b1;
                pos     <= pos + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tdm_sync_shaper.sv
module tdm_sync_shaper
    import tdm_fsync_pkg::*;
(
    input  frame_cfg_t        cfg,
    input  logic              running,
    input  logic [SLOT_W-1:0] slot_idx,
    input  logic [BIT_W-1:0]  bit_idx,
    input  logic [POS_W-1:0]  pos,
    output logic              fsync
);
    logic [TOT_W-1:0] total;
    logic [TOT_W-1:0] half;
    logic             second_half;
    logic             pulse;

    always_comb begin
        total       = TOT_W'({1'b0, cfg.slots} + 1'b1) * TOT_W'(slot_bits(cfg.size));
        half        = total >> 1;
        second_half = ({1'b0, pos} >= half);
        unique case (cfg.width)
            FSW_SLOT: pulse = (slot_idx == '0);
            FSW_HALF: pulse = second_half;
            FSW_BIT,
            FSW_RSVD: pulse = (slot_idx == '0) && (bit_idx == '0);
            default:  pulse = 1'b0;
        endcase
        fsync = running ? (pulse ^ cfg.inv) : 1'b0;
    end
endmodule

// File: rtl/tdm_fsync_gen.sv
module tdm_fsync_gen
    import tdm_fsync_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic [SLOT_W-1:0] cfg_slots,
    input  logic [SZ_W-1:0]   cfg_size,
    input  logic [1:0]        cfg_width,
    input  logic              cfg_inv,
    output logic              fsync,
    output logic [SLOT_W-1:0] slot_idx,
    output logic [BIT_W-1:0]  bit_idx,
    output logic              slot_start,
    output logic              frame_start
);
    seq_state_e       state_q, state_d;
    frame_cfg_t       cfg_in, cfg_q;
    logic             running;
    logic             step;
    logic             load;
    logic             frame_wrap;
    logic [POS_W-1:0] pos;
    logic [BIT_W-1:0] last_bit;

    always_comb begin
        cfg_in.slots = cfg_slots;
        cfg_in.size  = cfg_size;
        cfg_in.width = fsw_mode_e'(cfg_width);
        cfg_in.inv   = cfg_inv;
        last_bit     = BIT_W'(slot_bits(cfg_q.size) - 1'b1);
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state: IDLE_TO_RUN on first bit enable, RUN holds
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (bit_en) state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs and controls
    always_comb begin
        running     = (state_q == ST_RUN);
        step        = running && bit_en;
        load        = bit_en && (!running || frame_wrap);
        slot_start  = running && (bit_idx == '0);
        frame_start = slot_start && (slot_idx == '0);
    end

    tdm_cfg_shadow u_shadow (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .d     (cfg_in),
        .q     (cfg_q)
    );

    tdm_pos_counter #(
        .SLOT_W (SLOT_W),
        .BIT_W  (BIT_W),
        .POS_W  (POS_W)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (step),
        .last_bit   (last_bit),
        .last_slot  (cfg_q.slots),
        .bit_idx    (bit_idx),
        .slot_idx   (slot_idx),
        .pos        (pos),
        .frame_wrap (frame_wrap)
    );

    tdm_sync_shaper u_shape (
        .cfg      (cfg_q),
        .running  (running),
        .slot_idx (slot_idx),
        .bit_idx  (bit_idx),
        .pos      (pos),
        .fsync    (fsync)
    );
endmodule

// File: rtl/tdm_fsync_chk.sv
module tdm_fsync_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_en,
    input logic       running,
    input logic [1:0] width_q,
    input logic       inv_q,
    input logic       fsync,
    input logic [2:0] slot_idx,
    input logic [4:0] bit_idx,
    input logic       slot_start,
    input logic       frame_start
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (!fsync && !slot_start && !frame_start));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> ($stable(bit_idx) && $stable(slot_idx) && $stable(fsync)));

    p_short_frame_mark_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && frame_start) |=> !frame_start);

    p_bit_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (running && (width_q == 2'd0 || width_q == 2'd3)) |-> ((fsync ^ inv_q) == frame_start));

    p_slot_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (running && width_q == 2'd1) |-> ((fsync ^ inv_q) == (slot_idx == 3'd0)));

    p_frame_in_slot0_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (slot_start && slot_idx == 3'd0));

    p_first_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && bit_en) |=> (frame_start && slot_idx == 3'd0 && bit_idx == 5'd0));
endmodule

bind tdm_fsync_gen tdm_fsync_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_en      (bit_en),
    .running     (running),
    .width_q     (cfg_q.width),
    .inv_q       (cfg_q.inv),
    .fsync       (fsync),
    .slot_idx    (slot_idx),
    .bit_idx     (bit_idx),
    .slot_start  (slot_start),
    .frame_start (frame_start)
);

// File: tb/sim_tdm_fsync_gen.sv
module sim_tdm_fsync_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic [2:0] cfg_slots = 3'd0;
    logic [1:0] cfg_size = 2'd0;
    logic [1:0] cfg_width = 2'd0;
    logic       cfg_inv = 1'b0;
    logic       fsync, slot_start, frame_start;
    logic [2:0] slot_idx;
    logic [4:0] bit_idx;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    typedef struct {
        logic       fs;
        logic [2:0] sl;
        logic [4:0] bt;
        logic       ss;
        logic       fr;
        string      req;
    } exp_t;
    exp_t sb[$];

    // reference model state
    int m_run, m_bit, m_slot, m_pos;
    int m_slots, m_size, m_w, m_inv;

    always #5 clk = ~clk;

    tdm_fsync_gen u0 (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
        .cfg_slots(cfg_slots), .cfg_size(cfg_size),
        .cfg_width(cfg_width), .cfg_inv(cfg_inv),
        .fsync(fsync), .slot_idx(slot_idx), .bit_idx(bit_idx),
        .slot_start(slot_start), .frame_start(frame_start)
    );

    task automatic m_load();
        m_slots = int'(cfg_slots);
        m_size  = int'(cfg_size);
        m_w     = int'(cfg_width);
        m_inv   = int'(cfg_inv);
    endtask

    task automatic m_clear();
        m_run = 0; m_bit = 0; m_slot = 0; m_pos = 0;
        m_slots = 0; m_size = 0; m_w = 0; m_inv = 0;
    endtask

    task automatic push_exp();
        exp_t e;
        int raw, total;
        total = (m_slots + 1) * 8 * (m_size + 1);
        case (m_w)
            1: raw = (m_slot == 0) ? 1 : 0;
            2: raw = (m_pos >= total / 2) ? 1 : 0;
            default: raw = (m_slot == 0 && m_bit == 0) ? 1 : 0;
        endcase
        e.fs  = (m_run != 0) ? logic'((raw ^ m_inv) & 1) : 1'b0;
        e.sl  = 3'(m_slot);
        e.bt  = 5'(m_bit);
        e.ss  = (m_run != 0) && (m_bit == 0);
        e.fr  = (m_run != 0) && (m_bit == 0) && (m_slot == 0);
        e.req = cur_req;
        sb.push_back(e);
    endtask

    // driver: one call per clock edge
    task automatic cyc(input logic en);
        @(negedge clk);
        rst_n  = 1'b1;
        bit_en = en;
        if (en) begin
            if (m_run == 0) begin
                m_run = 1; m_bit = 0; m_slot = 0; m_pos = 0;
                m_load();
            end else if (m_bit == 8 * (m_size + 1) - 1) begin
                m_bit = 0;
                if (m_slot == m_slots) begin
                    m_slot = 0; m_pos = 0;
                    m_load();
                end else begin
                    m_slot++; m_pos++;
                end
            end else begin
                m_bit++; m_pos++;
            end
        end
        push_exp();
    endtask

    task automatic do_reset();
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            rst_n  = 1'b0;
            bit_en = 1'b0;
            m_clear();
            push_exp();
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cyc(1'b1);
    endtask

    // monitor / scoreboard
    always @(posedge clk) begin
        #2;
        if (sb.size() != 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (fsync !== e.fs) begin
                errors++;
                $display("FAIL %s fsync act=%b exp=%b t=%0t", e.req, fsync, e.fs, $time);
            end
            if (slot_idx !== e.sl || bit_idx !== e.bt) begin
                errors++;
                $display("FAIL %s idx act=%0d/%0d exp=%0d/%0d t=%0t", e.req,
                         slot_idx, bit_idx, e.sl, e.bt, $time);
            end
            if (slot_start !== e.ss || frame_start !== e.fr) begin
                errors++;
                $display("FAIL %s strobes act=%b%b exp=%b%b t=%0t", e.req,
                         slot_start, frame_start, e.ss, e.fr, $time);
            end
        end
    end

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        m_clear();
        // R1: quiet after reset, no enables
        cur_req = "R1";
        do_reset();
        for (int i = 0; i < 4; i++) cyc(1'b0);

        // R10, R4, R3, R8: two slots of 8 bits, bit pulse
        cur_req = "R10";
        cfg_slots = 3'd1; cfg_size = 2'd0; cfg_width = 2'd0; cfg_inv = 1'b0;
        run(1);
        cur_req = "R4";
        run(33);

        // R2: sparse enables hold outputs between steps
        cur_req = "R2";
        for (int i = 0; i < 20; i++) begin
            cyc(1'b1);
            cyc(1'b0);
            cyc(1'b0);
        end

        // R9: mid-frame change to slot mode, 4 slots of 16 bits
        cur_req = "R9";
        cfg_slots = 3'd3; cfg_size = 2'd1; cfg_width = 2'd1;
        run(20);
        cur_req = "R5";
        run(140);

        // R6: half mode, 3 slots of 8 bits (change inside slot 1)
        cur_req = "R6";
        cfg_slots = 3'd2; cfg_size = 2'd0; cfg_width = 2'd2; cfg_inv = 1'b0;
        run(80);

        // R7: inverted half mode, then inverted slot mode
        cur_req = "R7";
        cfg_inv = 1'b1;
        run(60);
        cfg_width = 2'd1; cfg_size = 2'd2;
        run(90);

        // R4: reserved width code acts as bit mode, 24-bit slots
        cur_req = "R4";
        cfg_width = 2'd3; cfg_inv = 1'b0;
        run(120);

        // R3 / R6: 8 slots of 32 bits, half mode inverted
        cur_req = "R3";
        cfg_slots = 3'd7; cfg_size = 2'd3; cfg_width = 2'd2; cfg_inv = 1'b1;
        run(600);

        // R8: 1 slot of 8 bits, each slot start is a frame start
        cur_req = "R8";
        cfg_slots = 3'd0; cfg_size = 2'd0; cfg_width = 2'd0; cfg_inv = 1'b0;
        run(300);

        // R1: reset mid-frame returns to idle
        cur_req = "R1";
        run(5);
        do_reset();
        for (int i = 0; i < 3; i++) cyc(1'b0);
        cur_req = "R10";
        cfg_slots = 3'd1; cfg_width = 2'd1;
        run(20);

        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule